// File: doc/BRIEF.md
# Decimal LSD Radix Sorter

This block puts a small array of unsigned integer keys, for example quantized distances coming out of a nearest-neighbour search, into ascending order. It treats each key as a fixed-width decimal number. For every decimal digit, starting at the ones place and moving upward, it makes one pass through the array. A pass clears ten digit counters, counts how many keys carry each digit value, turns the counts into end positions with a running sum, and moves every key into a result buffer. This move walks from the last key back to the first, so keys with equal digits keep their order. The buffer is then written back over the array before the next digit starts.

A host writes keys by index into the array while the sorter is idle. It then gives the number of valid keys and pulses start. When the done flag rises, it reads the sorted keys back through a combinational read port. The number of decimal digits, the key width and the array depth are parameters. Every pass takes a fixed number of cycles, because the sorter makes one array access per cycle.

Top module: `dec_radix_sorter`

## Requirements
- R1: After reset, `done` is low.
- R2: A start pulse with `n_keys` > 0 drives `done` low on the sampling edge. `done` goes high exactly DIGITS*(19+3*n_keys) clock edges after that edge.
- R3: When `done` rises, array entries 0 to n_keys-1 hold the loaded keys, duplicates included, in ascending order. This holds for any key below 10^DIGITS.
- R4: The digit passes are stable. Keys that share their low digits and differ only in a higher digit, up to and including the most significant one, come out correctly ordered.
- R5: Array entries at index n_keys and above are left unchanged by a sort.
- R6: A start pulse with `n_keys` = 0 sets `done` high on the sampling edge and changes no array entry.
- R7: A start pulse that arrives while a sort is running is ignored. The completion time and the result stay the same.
- R8: A key write (`load_en`) that arrives while a sort is running is ignored, and the array keeps the sorted result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write `load_key` at `load_idx` (honoured only when idle) |
| load_idx | input | $clog2(DEPTH) | Array index for a key write |
| load_key | input | KEY_W | Key value to write |
| n_keys | input | $clog2(DEPTH+1) | Number of valid keys, sampled with `start` |
| start | input | 1 | Begin a sort (honoured only when idle) |
| done | output | 1 | High once a sort has finished, cleared by the next start |
| rd_idx | input | $clog2(DEPTH) | Read index |
| rd_key | output | KEY_W | Array entry at `rd_idx` (combinational) |

## Verification
The bench feeds key sets whose low digits collide and that differ only in the top digit. A scatter that walked upward, or a pass that skipped the highest digit, would leave these keys misordered.

It also covers these cases:
- A sort over part of the array, with a check that the entries above `n_keys` are untouched. A loop bound off by one would corrupt them.
- A sort of zero keys. A design without a special case for this would hang or write garbage.
- A start pulse and a key write injected in the middle of a sort. A design that honoured either would restart or corrupt the array.

The exact completion cycle is checked on every sort, so a wrong phase length or pass count shows up as a latency mismatch.

// File: rtl/dec_radix_sorter.sv
module dec_radix_sorter #(
  parameter int KEY_W  = 16,
  parameter int DIGITS = 4,
  parameter int DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_en,
  input  logic [$clog2(DEPTH)-1:0]     load_idx,
  input  logic [KEY_W-1:0]             load_key,
  input  logic [$clog2(DEPTH+1)-1:0]   n_keys,
  input  logic                         start,
  output logic                         done,
  input  logic [$clog2(DEPTH)-1:0]     rd_idx,
  output logic [KEY_W-1:0]             rd_key
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int PW = $clog2(DIGITS+1);

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_HIST, S_PREF, S_SCAT, S_COPY} st_t;

  st_t              st;
  logic [KEY_W-1:0] mem [DEPTH];
  logic [KEY_W-1:0] res [DEPTH];
  logic [CW-1:0]    cnt [10];
  logic [CW-1:0]    idx, n;
  logic [PW-1:0]    pass;
  logic [31:0]      pow;

  logic [KEY_W-1:0] cur_key;
  logic [31:0]      quot;
  logic [3:0]       dig;
  logic [CW-1:0]    pos;

  assign cur_key = mem[idx[IW-1:0]];
  assign quot    = 32'(cur_key) / pow;
  assign dig     = 4'(quot % 32'd10);
  assign pos     = cnt[dig] - 1'b1;
  assign rd_key  = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      done <= 1'b0;
      idx  <= '0;
      n    <= '0;
      pass <= '0;
      pow  <= 32'd1;
    end else begin
      case (st)
        S_IDLE: begin
          if (load_en) mem[load_idx] <= load_key;
          if (start) begin
            pass <= '0;
            pow  <= 32'd1;
            idx  <= '0;
            n    <= n_keys;
            if (n_keys == '0) begin
              done <= 1'b1;
            end else begin
              done <= 1'b0;
              st   <= S_CLR;
            end
          end
        end
        S_CLR: begin
          cnt[idx[3:0]] <= '0;
          if (idx == CW'(9)) begin
            idx <= '0;
            st  <= S_HIST;
          end else idx <= idx + 1'b1;
        end
        S_HIST: begin
          cnt[dig] <= cnt[dig] + 1'b1;
          if (idx == n - 1'b1) begin
            idx <= CW'(1);
            st  <= S_PREF;
          end else idx <= idx + 1'b1;
        end
        S_PREF: begin
          cnt[idx[3:0]] <= cnt[idx[3:0]] + cnt[idx[3:0] - 4'd1];
          if (idx == CW'(9)) begin
            idx <= n - 1'b1;
            st  <= S_SCAT;
          end else idx <= idx + 1'b1;
        end
        S_SCAT: begin
          res[pos[IW-1:0]] <= cur_key;
          cnt[dig]         <= pos;
          if (idx == '0) st <= S_COPY;
          else idx <= idx - 1'b1;
        end
        S_COPY: begin
          mem[idx[IW-1:0]] <= res[idx[IW-1:0]];
          if (idx == n - 1'b1) begin
            idx <= '0;
            if (pass == PW'(DIGITS - 1)) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              pass <= pass + 1'b1;
              pow  <= pow * 32'd10;
              st   <= S_CLR;
            end
          end else idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: a finished sort always leaves the machine idle
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> st == S_IDLE);

  // R2: done only drops when a start was accepted
  a_r2_done_falls_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(start));

  // R3: the running sum must cover exactly the valid keys
  a_r3_prefix_total: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCAT && $past(st) == S_PREF) |-> cnt[9] == n);

  // R4: every scattered key finds a free slot in its bucket
  a_r4_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SCAT |-> cnt[dig] != '0);

  // R2: the pass counter never runs past the digit count
  a_r2_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pass) < DIGITS);
endmodule

// File: tb/dec_radix_sorter_test.sv
`timescale 1ns/1ps
module dec_radix_sorter_test;
  localparam int KEY_W  = 16;
  localparam int DIGITS = 4;
  localparam int DEPTH  = 16;
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_en = 1'b0;
  logic [IW-1:0] load_idx = '0;
  logic [KEY_W-1:0] load_key = '0;
  logic [CW-1:0] n_keys = '0;
  logic start = 1'b0;
  logic done;
  logic [IW-1:0] rd_idx = '0;
  logic [KEY_W-1:0] rd_key;

  int n_chk = 0, n_bad = 0;
  int model [DEPTH];
  int exp_q [$];
  string tag_q [$];
  logic mon_on = 1'b0;

  always #2.5 clk = ~clk;

  dec_radix_sorter #(.KEY_W(KEY_W), .DIGITS(DIGITS), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
    .load_key(load_key), .n_keys(n_keys), .start(start), .done(done),
    .rd_idx(rd_idx), .rd_key(rd_key));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(int'(rd_key) == e, t, int'(rd_key), e);
    end
  end

  task automatic load(input int i, input int k);
    @(negedge clk);
    load_en = 1'b1; load_idx = IW'(i); load_key = KEY_W'(k);
    model[i] = k;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic read_all(input int n, input string tag);
    for (int i = 0; i < DEPTH; i++) begin
      exp_q.push_back(model[i]);
      tag_q.push_back(i < n ? tag : "R5 untouched");
      @(negedge clk);
      rd_idx = IW'(i);
      mon_on = 1'b1;
    end
    @(negedge clk);
    mon_on = 1'b0;
  endtask

  task automatic sort(input int n, input bit poke, input string tag);
    int c;
    @(negedge clk);
    n_keys = CW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(done == 1'b1, "R6 empty sort done", int'(done), 1);
    end else begin
      chk(done == 1'b0, "R2 done cleared", int'(done), 0);
      c = 0;
      while (1) begin
        @(negedge clk);
        c++;
        if (c == 6) begin start = 1'b0; load_en = 1'b0; end
        if (c == 5 && poke) begin
          start = 1'b1; load_en = 1'b1; load_idx = '0; load_key = KEY_W'(9999);
        end
        if (done || c > 20000) break;
      end
      chk(c == DIGITS*(19+3*n), poke ? "R7 latency with busy start" : "R2 latency",
          c, DIGITS*(19+3*n));
      for (int i = 1; i < n; i++) begin
        int k = model[i];
        int j = i - 1;
        while (j >= 0 && model[j] > k) begin
          model[j+1] = model[j];
          j--;
        end
        model[j+1] = k;
      end
    end
    read_all(n, tag);
  endtask

  initial begin
    #750000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 idle done", int'(done), 0);

    begin
      int v [8] = '{503, 17, 9000, 17, 0, 4321, 88, 503};
      for (int i = 0; i < 8; i++) load(i, v[i]);
      for (int i = 8; i < DEPTH; i++) load(i, 7000 + i);
      sort(8, 1'b0, "R3 ascending with duplicates");
    end

    begin
      int v [16] = '{1234, 5234, 234, 9234, 34, 4, 7004, 1004,
                     9999, 8234, 2234, 6004, 14, 1000, 0, 9000};
      for (int i = 0; i < 16; i++) load(i, v[i]);
      sort(16, 1'b0, "R4 stable shared low digits");
    end

    begin
      int v [5] = '{42, 7, 3100, 2999, 5};
      for (int i = 0; i < 5; i++) load(i, v[i]);
      for (int i = 5; i < DEPTH; i++) load(i, 100 * i + 3);
      sort(5, 1'b0, "R3 partial sort");
    end

    sort(0, 1'b0, "R6 empty sort unchanged");

    begin
      int v [6] = '{600, 60, 6, 6000, 66, 606};
      for (int i = 0; i < 6; i++) load(i, v[i]);
      sort(6, 1'b1, "R8 busy load ignored");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule